// File: doc/BRIEF.md
# SIMD Lane-Width Vector ALU

This block is the arithmetic stage of a vector unit. It accepts two source vectors of K elements, each 32 bits wide, together with an operation code and a lane-width code, and returns one result vector. Each 32-bit element can be treated as four byte lanes, two halfword lanes or one word lane. In the 64-bit mode, two neighbouring elements are joined into a single lane. Carries, borrows and shifted bits cross a slice boundary only when that boundary lies inside a lane.

The issue logic raises `start_i` for one cycle with the operands on the inputs. All K elements are computed in parallel. On the next clock edge the result is captured in an output register, and `done_o` pulses for one cycle. The result then holds until the next start. A multiply request at a width the multiplier does not support raises `illegal_o` and returns an all-zero vector.

Top module: `simd_lane_alu`

## Requirements
- R1: Op code 0 (AND), 1 (OR) and 2 (XOR) apply the bitwise function to every bit of the vectors, whatever the width code.
- R2: Width code 0 selects 8-bit lanes. Op 3 (ADD) and op 4 (SUB) then wrap modulo 2^8 in each byte, with no carry or borrow into the next byte.
- R3: Width code 1 selects 16-bit lanes. ADD and SUB then wrap modulo 2^16 in each halfword, with no carry or borrow across halfwords.
- R4: Width code 2 selects 32-bit lanes. ADD and SUB then act on each element alone, with no carry or borrow between elements.
- R5: Width code 3 pairs element 2i (low half) with element 2i+1 (high half) into one 64-bit lane. The carry or borrow out of the low half feeds the high half.
- R6: Op 5 (shift left) and op 6 (shift right) move every lane by one bit and fill with zero. In byte, halfword and word modes, a bit shifted out of a lane is dropped and does not enter the neighbouring lane.
- R7: In width code 3, a left shift moves bit 31 of the low element into bit 0 of the high element. A right shift moves bit 0 of the high element into bit 31 of the low element.
- R8: Op 7 (MUL) with width code 1 puts in each element the 32-bit product of the low 16 bits of both operands.
- R9: MUL with width code 0 puts the product of the two byte-0 values in bits 15:0 of each element, and the product of the two byte-2 values in bits 31:16.
- R10: MUL with width code 2 or 3 (or on a build without the multiplier) raises illegal_o with done_o and gives an all-zero result.
- R11: The result is registered one clock after start_i, and done_o pulses high for that one cycle. Without start_i, result_o keeps its value and done_o stays low.
- R12: During reset, result_o is zero and done_o and illegal_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Capture strobe for one operation |
| op_i | input | 3 | Operation code |
| width_i | input | 2 | Lane width code |
| src_a_i | input | 32*K | First source vector, element e at bits 32e+31:32e |
| src_b_i | input | 32*K | Second source vector |
| result_o | output | 32*K | Registered result vector |
| done_o | output | 1 | One-cycle pulse when result_o is updated |
| illegal_o | output | 1 | Pulses with done_o for an unsupported multiply |

## Verification
Several properties are checked on every cycle:
- a start always produces a done pulse one cycle later;
- the result holds steady when there is no start;
- an illegal multiply comes with done and a zero vector;
- a bitwise AND reaches the output unchanged.

Whether carries and shifted bits are stopped or passed at the right boundaries for each width can only be shown by the bench's scenarios. The same holds for the quadword pairing and the byte and halfword product placement. These scenarios use all-ones operands, borrows from zero, and edge bits set in every lane, compared against a lane-sliced reference model.

// File: rtl/simd_alu_pkg.sv
package simd_alu_pkg;
  localparam int ELEM_W = 32;

  typedef enum logic [2:0] {
    OP_AND = 3'd0,
    OP_OR  = 3'd1,
    OP_XOR = 3'd2,
    OP_ADD = 3'd3,
    OP_SUB = 3'd4,
    OP_SHL = 3'd5,
    OP_SHR = 3'd6,
    OP_MUL = 3'd7
  } alu_op_e;

  typedef enum logic [1:0] {
    LW_BYTE = 2'd0,
    LW_HALF = 2'd1,
    LW_WORD = 2'd2,
    LW_QUAD = 2'd3
  } lane_w_e;
endpackage

// File: rtl/simd_addsub_elem.sv
module simd_addsub_elem import simd_alu_pkg::*; #(
  parameter int EW = ELEM_W
) (
  input  logic [EW-1:0] a_i,
  input  logic [EW-1:0] b_i,
  input  logic          sub_i,
  input  lane_w_e       width_i,
  input  logic          link_i,
  input  logic          cin_i,
  output logic [EW-1:0] sum_o,
  output logic          cout_o
);
  localparam int NB = EW / 8;

  always_comb begin
    logic [8:0] t;
    logic       c;
    logic       chain;
    c = link_i ? cin_i : sub_i;
    sum_o = '0;
    for (int j = 0; j < NB; j++) begin
      chain = (width_i == LW_WORD) || (width_i == LW_QUAD) ||
              ((width_i == LW_HALF) && (j % 2 == 1));
      if (j > 0 && !chain) c = sub_i;
      t = {1'b0, a_i[8*j +: 8]} + {1'b0, b_i[8*j +: 8] ^ {8{sub_i}}} + {8'd0, c};
      sum_o[8*j +: 8] = t[7:0];
      c = t[8];
    end
    cout_o = c;
  end
endmodule

// File: rtl/simd_shift_elem.sv
module simd_shift_elem import simd_alu_pkg::*; #(
  parameter int EW = ELEM_W
) (
  input  logic [EW-1:0] a_i,
  input  logic          left_i,
  input  lane_w_e       width_i,
  input  logic          link_l_i,
  input  logic          nb_l_i,
  input  logic          link_r_i,
  input  logic          nb_r_i,
  output logic [EW-1:0] res_o
);
  localparam int NB = EW / 8;

  always_comb begin
    logic edge_lane;
    res_o = left_i ? (a_i << 1) : (a_i >> 1);
    for (int j = 0; j < NB; j++) begin
      if (left_i) begin
        // lowest bit of each lane receives zero or the neighbour bit
        edge_lane = (width_i == LW_BYTE) || ((width_i == LW_HALF) && (j % 2 == 0)) || (j == 0);
        if (edge_lane) res_o[8*j] = (j == 0 && link_l_i) ? nb_l_i : 1'b0;
      end else begin
        edge_lane = (width_i == LW_BYTE) || ((width_i == LW_HALF) && (j % 2 == 1)) || (j == NB-1);
        if (edge_lane) res_o[8*j+7] = (j == NB-1 && link_r_i) ? nb_r_i : 1'b0;
      end
    end
  end
endmodule

// File: rtl/simd_mul_elem.sv
module simd_mul_elem #(
  parameter int EW = 32
) (
  input  logic [EW-1:0] a_i,
  input  logic [EW-1:0] b_i,
  input  logic          half_i,
  output logic [EW-1:0] prod_o
);
  logic [31:0] p_half;
  logic [15:0] p_b0, p_b2;
  logic        unused_hi;

  assign p_half = 32'(a_i[15:0]) * 32'(b_i[15:0]);
  assign p_b0   = 16'(a_i[7:0]) * 16'(b_i[7:0]);
  assign p_b2   = 16'(a_i[23:16]) * 16'(b_i[23:16]);
  assign prod_o = half_i ? EW'(p_half) : EW'({p_b2, p_b0});
  assign unused_hi = ^{a_i[EW-1:24], b_i[EW-1:24]};
endmodule

// File: rtl/simd_lane_alu.sv
module simd_lane_alu import simd_alu_pkg::*; #(
  parameter int K       = 16,
  parameter bit HAS_MUL = 1'b1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_i,
  input  logic [2:0]           op_i,
  input  logic [1:0]           width_i,
  input  logic [K*ELEM_W-1:0]  src_a_i,
  input  logic [K*ELEM_W-1:0]  src_b_i,
  output logic [K*ELEM_W-1:0]  result_o,
  output logic                 done_o,
  output logic                 illegal_o
);
  localparam int EW = ELEM_W;
  localparam int VW = K * EW;

  alu_op_e op;
  lane_w_e lw;
  logic    quad, is_sub, is_left, illegal_d, unused_cy;
  logic [K-1:0]  cy;
  logic [VW-1:0] sum_v, shf_v, mul_v, res_d;
  logic [VW-1:0] res_q;
  logic          done_q, ill_q;

  assign op      = alu_op_e'(op_i);
  assign lw      = lane_w_e'(width_i);
  assign quad    = (lw == LW_QUAD);
  assign is_sub  = (op == OP_SUB);
  assign is_left = (op == OP_SHL);

  for (genvar e = 0; e < K; e++) begin : g_elem
    localparam bit ODD = (e % 2) == 1;
    logic cin, lnb, rnb;

    if (ODD) begin : g_hi
      assign cin = cy[e-1];
      assign lnb = src_a_i[(e-1)*EW + EW-1];
    end else begin : g_lo
      assign cin = 1'b0;
      assign lnb = 1'b0;
    end

    if (!ODD && (e+1 < K)) begin : g_rnb
      assign rnb = src_a_i[(e+1)*EW];
    end else begin : g_rnb0
      assign rnb = 1'b0;
    end

    simd_addsub_elem #(.EW(EW)) u_add (
      .a_i    (src_a_i[e*EW +: EW]),
      .b_i    (src_b_i[e*EW +: EW]),
      .sub_i  (is_sub),
      .width_i(lw),
      .link_i (quad & ODD),
      .cin_i  (cin),
      .sum_o  (sum_v[e*EW +: EW]),
      .cout_o (cy[e])
    );

    simd_shift_elem #(.EW(EW)) u_shf (
      .a_i     (src_a_i[e*EW +: EW]),
      .left_i  (is_left),
      .width_i (lw),
      .link_l_i(quad & ODD),
      .nb_l_i  (lnb),
      .link_r_i(quad & !ODD),
      .nb_r_i  (rnb),
      .res_o   (shf_v[e*EW +: EW])
    );

    if (HAS_MUL) begin : g_mul
      simd_mul_elem #(.EW(EW)) u_mul (
        .a_i   (src_a_i[e*EW +: EW]),
        .b_i   (src_b_i[e*EW +: EW]),
        .half_i(lw == LW_HALF),
        .prod_o(mul_v[e*EW +: EW])
      );
    end else begin : g_nomul
      assign mul_v[e*EW +: EW] = '0;
    end
  end

  assign unused_cy = ^cy;

  assign illegal_d = (op == OP_MUL) && (!HAS_MUL || lw == LW_WORD || lw == LW_QUAD);

  always_comb begin
    unique case (op)
      OP_AND:         res_d = src_a_i & src_b_i;
      OP_OR:          res_d = src_a_i | src_b_i;
      OP_XOR:         res_d = src_a_i ^ src_b_i;
      OP_ADD, OP_SUB: res_d = sum_v;
      OP_SHL, OP_SHR: res_d = shf_v;
      default:        res_d = illegal_d ? '0 : mul_v;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_q  <= '0;
      done_q <= 1'b0;
      ill_q  <= 1'b0;
    end else begin
      done_q <= start_i;
      ill_q  <= start_i & illegal_d;
      if (start_i) res_q <= res_d;
    end
  end

  assign result_o  = res_q;
  assign done_o    = done_q;
  assign illegal_o = ill_q;

  // R11
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> done_o);
  // R11
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> ($stable(result_o) && !done_o));
  // R10
  illegal_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> (result_o == '0 && done_o));
  // R1
  bitwise_and_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && op_i == 3'd0) |=> (result_o == $past(src_a_i & src_b_i)));
  // R12
  reset_state_chk: assert property (@(posedge clk_i)
    !rst_ni |-> (result_o == '0 && !done_o && !illegal_o));
endmodule

// File: tb/simd_lane_alu_tb.sv
module simd_lane_alu_tb;
  localparam int K = 4;
  localparam int N = K * 32;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          start_i = 1'b0;
  logic [2:0]    op_i = '0;
  logic [1:0]    width_i = '0;
  logic [N-1:0]  src_a_i = '0;
  logic [N-1:0]  src_b_i = '0;
  logic [N-1:0]  result_o;
  logic          done_o, illegal_o;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  logic [N-1:0] exp_res = '0;
  logic         exp_done = 1'b0, exp_ill = 1'b0;

  always #10 clk_i = ~clk_i;

  simd_lane_alu #(.K(K), .HAS_MUL(1'b1)) u_dut (
    .clk_i, .rst_ni, .start_i, .op_i, .width_i,
    .src_a_i, .src_b_i, .result_o, .done_o, .illegal_o
  );

  function automatic bit is_illegal(int op, int w);
    return (op == 7) && (w >= 2);
  endfunction

  function automatic logic [N-1:0] model(int op, int w, logic [N-1:0] a, logic [N-1:0] b);
    logic [N-1:0] r = '0;
    int lw = 8 << w;
    logic [63:0] m = (lw == 64) ? '1 : ((64'd1 << lw) - 64'd1);
    case (op)
      0: r = a & b;
      1: r = a | b;
      2: r = a ^ b;
      7: begin
        if (!is_illegal(op, w)) begin
          for (int e = 0; e < K; e++) begin
            logic [31:0] ea = a[e*32 +: 32];
            logic [31:0] eb = b[e*32 +: 32];
            if (w == 1) r[e*32 +: 32] = 32'(ea[15:0]) * 32'(eb[15:0]);
            else r[e*32 +: 32] = {16'(16'(ea[23:16]) * 16'(eb[23:16])),
                                  16'(16'(ea[7:0]) * 16'(eb[7:0]))};
          end
        end
      end
      default: begin
        for (int l = 0; l < N / lw; l++) begin
          logic [63:0] la = 64'(a >> (l*lw)) & m;
          logic [63:0] lb = 64'(b >> (l*lw)) & m;
          logic [63:0] lr;
          case (op)
            3: lr = (la + lb) & m;
            4: lr = (la - lb) & m;
            5: lr = (la << 1) & m;
            default: lr = la >> 1;
          endcase
          r = r | (N'(lr) << (l*lw));
        end
      end
    endcase
    return r;
  endfunction

  function automatic string tag_of(int op, int w);
    if (op <= 2) return "R1";
    if (op == 3 || op == 4) begin
      case (w)
        0: return "R2";
        1: return "R3";
        2: return "R4";
        default: return "R5";
      endcase
    end
    if (op == 5 || op == 6) return (w == 3) ? "R7" : "R6";
    if (w == 0) return "R9";
    if (w == 1) return "R8";
    return "R10";
  endfunction

  task automatic check(string tag);
    total++;
    if (result_o !== exp_res || done_o !== exp_done || illegal_o !== exp_ill) begin
      bad++;
      $display("FAIL %s: res=%h done=%b ill=%b expected res=%h done=%b ill=%b",
               tag, result_o, done_o, illegal_o, exp_res, exp_done, exp_ill);
    end
  endtask

  // called at a falling edge; applies inputs for one cycle then checks
  task automatic step(bit st, int op, int w, logic [N-1:0] a, logic [N-1:0] b, string tag);
    start_i = st;
    op_i    = op[2:0];
    width_i = w[1:0];
    src_a_i = a;
    src_b_i = b;
    if (st) exp_res = model(op, w, a, b);
    exp_done = st;
    exp_ill  = st && is_illegal(op, w);
    @(posedge clk_i);
    @(negedge clk_i);
    start_i = 1'b0;
    check(tag);
  endtask

  function automatic logic [N-1:0] rnd_vec();
    logic [N-1:0] v;
    for (int e = 0; e < K; e++) v[e*32 +: 32] = $urandom;
    return v;
  endfunction

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!finished) begin
      bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] ones = '1;
    repeat (3) @(negedge clk_i);
    check("R12");
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R12");

    step(1, 0, 0, {4{32'hF0F0_A5A5}}, {4{32'h3C3C_FF00}}, "R1");
    step(1, 1, 3, {4{32'h1234_0000}}, {4{32'h0000_8765}}, "R1");
    step(1, 2, 1, {4{32'hFFFF_0000}}, {4{32'h0F0F_0F0F}}, "R1");
    step(1, 3, 0, ones, {4{32'h0101_0101}}, "R2");
    step(1, 4, 0, '0, {4{32'h0101_0101}}, "R2");
    step(1, 3, 1, ones, {4{32'h0001_0001}}, "R3");
    step(1, 4, 1, '0, {4{32'h0001_0001}}, "R3");
    step(1, 3, 2, ones, {4{32'h0000_0001}}, "R4");
    step(1, 4, 2, '0, {4{32'h0000_0001}}, "R4");
    step(1, 3, 3, {2{32'h0000_0005, 32'hFFFF_FFFF}}, {2{32'h0000_0000, 32'h0000_0001}}, "R5");
    step(1, 4, 3, '0, {2{32'h0000_0000, 32'h0000_0001}}, "R5");
    step(1, 5, 0, {4{32'h8080_8080}}, '0, "R6");
    step(1, 6, 0, {4{32'h0101_0101}}, '0, "R6");
    step(1, 5, 1, {4{32'h8000_8000}}, '0, "R6");
    step(1, 6, 1, {4{32'h0001_0001}}, '0, "R6");
    step(1, 5, 2, {4{32'h8000_0001}}, '0, "R6");
    step(1, 6, 2, {4{32'h8000_0001}}, '0, "R6");
    step(1, 5, 3, {2{32'h0000_0000, 32'h8000_0000}}, '0, "R7");
    step(1, 6, 3, {2{32'h0000_0001, 32'h0000_0000}}, '0, "R7");
    step(1, 7, 1, {4{32'hA3BF_74E5}}, {4{32'h03C7_A483}}, "R8");
    step(1, 7, 1, ones, ones, "R8");
    step(1, 7, 0, {4{32'h11FF_22FF}}, {4{32'h33FF_44FF}}, "R9");
    step(1, 7, 2, ones, ones, "R10");
    step(1, 7, 3, ones, ones, "R10");
    step(1, 3, 2, {4{32'h0000_0010}}, {4{32'h0000_0020}}, "R11");
    step(0, 4, 0, ones, ones, "R11");
    step(0, 2, 3, rnd_vec(), rnd_vec(), "R11");

    for (int i = 0; i < 400; i++) begin
      int op = int'($urandom_range(0, 7));
      int w  = int'($urandom_range(0, 3));
      bit st = ($urandom_range(0, 7) != 0);
      step(st, op, w, rnd_vec(), rnd_vec(), st ? tag_of(op, w) : "R11");
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule